// File: doc/BRIEF.md
# Command Byte Feeder for a TPM-Style Status/FIFO Register Window

This engine sits on the host side of a trusted-module register window and delivers one command, byte by byte, into the device's data FIFO register. A start pulse with a non-zero length begins a run. The engine first polls the status register until the device says it is ready for a command. It then writes bytes in chunks. The size of each chunk is limited by the burst count that the device advertises. The engine holds the final byte back, and writes it on its own only after the device has confirmed that it still expects more data. When the device reports that it expects nothing further, the engine writes the start-execution bit. Only locality 0 is used.

Command bytes arrive on a first-word-fall-through byte stream. `src_data` is valid while `src_valid` is high, and `src_pop` tells the source to advance. All device traffic goes over a simple request/acknowledge register master port. Each wait on the device is paced by a poll tick of `TICK_CYCLES` clocks and is bounded by `TIMEOUT_POLLS` status reads. A run ends with a one-cycle `done` pulse and a 2-bit result code.

Top module: `tis_cmd_sender`

## Requirements
- R1: While reset is high, and afterwards until a start is accepted, `busy`, `done`, `reg_req` and `src_pop` are 0 and `err_code` is 0.
- R2: A start with `cmd_len` = 0 makes no bus access and consumes no byte. It gives `done` on the next cycle with `err_code` = 2 (protocol).
- R3: The first accesses are reads of the status word at offset 0x018. They repeat once per poll tick until the commandReady bit (bit 6) is 1, and no byte is written before that. If `TIMEOUT_POLLS` reads all show bit 6 = 0, the run ends with `err_code` = 1 (timeout).
- R4: Command bytes are written, in stream order, to offset 0x024 with the byte in bits 7:0. Between two status reads, the number of bytes written never exceeds the burst count (status bits 23:8) returned by the earlier read.
- R5: Each chunk holds min(burst count, bytes remaining − 1) bytes. After each chunk, the status word is re-read once per tick until stsValid (bit 7) is 1.
- R6: If a status read taken after a chunk shows stsValid = 1 and Expect (bit 3) = 0, the run ends with `err_code` = 2. No further byte or go write follows.
- R7: While the burst count reads 0, the status word is re-read once per tick. After `TIMEOUT_POLLS` re-reads that all show a zero burst, the run ends with `err_code` = 1.
- R8: The final byte is written alone, directly after a status read that shows a non-zero burst. Status is then polled until stsValid = 1. If Expect is still 1 at that point, the run ends with `err_code` = 2 and no go write follows.
- R9: On success the engine writes 0x20 (tpmGo, bit 5) to offset 0x018. After that write is acknowledged, `done` pulses for exactly one cycle with `err_code` = 0.
- R10: A bus request holds its address, direction and write data unchanged until it is acknowledged. A start that arrives while `busy` is high is ignored.
- R11: `src_pop` pulses once for each byte taken from the stream, so a successful run pops exactly `cmd_len` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled while idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| src_valid | input | 1 | Stream byte present |
| src_data | input | 8 | Current stream byte |
| src_pop | output | 1 | Stream byte consumed; advance |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Byte offset within the locality 0 window |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | One-cycle access completion |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 none, 1 timeout, 2 protocol |

## Verification
The assertions rely on the device raising `reg_ack` only while `reg_req` is high, for one cycle at a time, and never in the cycle in which the request first appears. They also rely on `src_data` staying put while a byte is offered, until the following pop. The bench device model enforces both rules. It answers each request on the falling edge after it sees the request, drops the acknowledge on the next falling edge, and advances the byte source only when it observes `src_pop`. Status contents, such as readiness delay, burst values, valid lag and the point at which Expect clears, are set for each scenario from a few model knobs, so each path through the sequencer can be reached on purpose.

// File: rtl/tis_tx_pkg.sv
`timescale 1ns/1ps
package tis_tx_pkg;

    localparam int BURST_W   = 16;
    localparam int STS_OFS   = 'h018;
    localparam int FIFO_OFS  = 'h024;
    localparam int BIT_VALID = 7;
    localparam int BIT_READY = 6;
    localparam int BIT_GO    = 5;
    localparam int BIT_EXP   = 3;
    localparam int BURST_LSB = 8;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_PROTO   = 2'd2
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RDY_RD,
        S_BST_RD,
        S_CHUNK,
        S_VAL_RD,
        S_LAST_WR,
        S_FIN_RD,
        S_GO,
        S_WAIT
    } st_e;

    typedef struct packed {
        logic               valid;
        logic               ready;
        logic               expect_more;
        logic [BURST_W-1:0] burst;
    } sts_t;

    function automatic sts_t decode_sts(input logic [31:0] w);
        sts_t s;
        s.valid       = w[BIT_VALID];
        s.ready       = w[BIT_READY];
        s.expect_more = w[BIT_EXP];
        s.burst       = w[BURST_LSB +: BURST_W];
        return s;
    endfunction

endpackage

// File: rtl/tis_poll_ctl.sv
`timescale 1ns/1ps
module tis_poll_ctl #(
    parameter int TICK_CYCLES   = 200,
    parameter int TIMEOUT_POLLS = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fail,
    input  logic arm,
    output logic tick,
    output logic last
);
    localparam int TCW = $clog2(TICK_CYCLES + 1);
    localparam int PCW = $clog2(TIMEOUT_POLLS + 1);

    logic [PCW-1:0] n_fail;
    logic [TCW-1:0] dly;
    logic           run;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_fail <= '0;
            dly    <= '0;
            run    <= 1'b0;
        end else begin
            if (clr)
                n_fail <= '0;
            else if (fail)
                n_fail <= n_fail + 1'b1;

            if (fail || arm) begin
                dly <= TCW'(TICK_CYCLES - 1);
                run <= 1'b1;
            end else if (run) begin
                if (dly == '0)
                    run <= 1'b0;
                else
                    dly <= dly - 1'b1;
            end
        end
    end

    assign tick = run && (dly == '0);
    assign last = (n_fail == PCW'(TIMEOUT_POLLS - 1));

    // R3
    poll_range_chk: assert property (@(posedge clk) disable iff (rst)
        n_fail < PCW'(TIMEOUT_POLLS));

endmodule

// File: rtl/tis_tx_counts.sv
`timescale 1ns/1ps
module tis_tx_counts
    import tis_tx_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CW    = (LEN_W > BURST_W) ? LEN_W : BURST_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_len,
    input  logic [LEN_W-1:0]   len,
    input  logic               load_chunk,
    input  logic [BURST_W-1:0] burst,
    input  logic               dec,
    output logic [LEN_W-1:0]   rem,
    output logic [CW-1:0]      chunk_left,
    output logic               rem_one
);
    logic [CW-1:0] room;
    logic [CW-1:0] burst_x;
    logic [CW-1:0] chunk_n;

    always_comb begin
        room    = CW'(rem) - CW'(1);
        burst_x = CW'(burst);
        chunk_n = (burst_x < room) ? burst_x : room;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem        <= '0;
            chunk_left <= '0;
        end else begin
            if (load_len)
                rem <= len;
            else if (dec)
                rem <= rem - 1'b1;

            if (load_chunk)
                chunk_left <= chunk_n;
            else if (dec && chunk_left != '0)
                chunk_left <= chunk_left - 1'b1;
        end
    end

    assign rem_one = (rem == LEN_W'(1));

    // R5
    chunk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (chunk_left == '0) || (CW'(rem) > chunk_left));

endmodule

// File: rtl/tis_cmd_sender.sv
`timescale 1ns/1ps
module tis_cmd_sender
    import tis_tx_pkg::*;
#(
    parameter int LEN_W         = 16,
    parameter int ADDR_W        = 12,
    parameter int TICK_CYCLES   = 200,
    parameter int TIMEOUT_POLLS = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_pop,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code
);
    localparam int CW = (LEN_W > BURST_W) ? LEN_W : BURST_W;
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(FIFO_OFS);
    localparam logic [31:0]       GO_WORD = 32'(1) << BIT_GO;

    st_e  state_q, state_n, ret_q, ret_n;
    err_e err_q, err_n;
    logic req_q, req_n, we_q, we_n, pop_n, done_q, done_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [31:0]       wdata_q, wdata_n;

    logic load_len, load_chunk, cnt_dec;
    logic p_clr, p_fail, p_arm, p_tick, p_last;
    logic [LEN_W-1:0] rem;
    logic [CW-1:0]    chunk_left;
    logic             rem_one;
    logic             ack_hit;
    sts_t             sts;

    tis_poll_ctl #(.TICK_CYCLES(TICK_CYCLES), .TIMEOUT_POLLS(TIMEOUT_POLLS)) poll_i (
        .clk(clk), .rst(rst), .clr(p_clr), .fail(p_fail), .arm(p_arm),
        .tick(p_tick), .last(p_last)
    );

    tis_tx_counts #(.LEN_W(LEN_W), .CW(CW)) cnt_i (
        .clk(clk), .rst(rst), .load_len(load_len), .len(cmd_len),
        .load_chunk(load_chunk), .burst(sts.burst), .dec(cnt_dec),
        .rem(rem), .chunk_left(chunk_left), .rem_one(rem_one)
    );

    assign ack_hit = req_q && reg_ack;
    assign sts     = decode_sts(reg_rdata);

    always_comb begin
        state_n = state_q;  ret_n  = ret_q;   err_n   = err_q;
        req_n   = req_q;    we_n   = we_q;    addr_n  = addr_q;
        wdata_n = wdata_q;  pop_n  = 1'b0;    done_n  = 1'b0;
        load_len = 1'b0; load_chunk = 1'b0; cnt_dec = 1'b0;
        p_clr = 1'b0; p_fail = 1'b0; p_arm = 1'b0;

        // any status-read state: issue the read when the port is free
        if ((state_q == S_RDY_RD || state_q == S_BST_RD ||
             state_q == S_VAL_RD || state_q == S_FIN_RD) && !req_q) begin
            req_n = 1'b1; we_n = 1'b0; addr_n = A_STS;
        end
        if (ack_hit)
            req_n = 1'b0;

        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    err_n = ERR_NONE;
                    if (cmd_len == '0) begin
                        done_n = 1'b1; err_n = ERR_PROTO;
                    end else begin
                        load_len = 1'b1; p_clr = 1'b1; state_n = S_RDY_RD;
                    end
                end
            end
            S_RDY_RD, S_BST_RD, S_VAL_RD, S_FIN_RD: begin
                if (ack_hit) begin
                    logic good;
                    unique case (state_q)
                        S_RDY_RD: good = sts.ready;
                        S_BST_RD: good = (sts.burst != '0);
                        default:  good = sts.valid;
                    endcase
                    if (!good) begin
                        if (p_last) begin
                            state_n = S_IDLE; done_n = 1'b1; err_n = ERR_TIMEOUT;
                        end else begin
                            p_fail = 1'b1; ret_n = state_q; state_n = S_WAIT;
                        end
                    end else if (state_q == S_FIN_RD) begin
                        if (sts.expect_more) begin
                            state_n = S_IDLE; done_n = 1'b1; err_n = ERR_PROTO;
                        end else begin
                            state_n = S_GO;
                        end
                    end else if (state_q == S_VAL_RD && !sts.expect_more) begin
                        state_n = S_IDLE; done_n = 1'b1; err_n = ERR_PROTO;
                    end else if (state_q == S_VAL_RD && rem_one && sts.burst != '0) begin
                        state_n = S_LAST_WR;
                    end else if (sts.burst == '0) begin
                        p_clr = 1'b1; p_arm = 1'b1; ret_n = S_BST_RD; state_n = S_WAIT;
                    end else begin
                        load_chunk = 1'b1; state_n = S_CHUNK;
                    end
                end
            end
            S_CHUNK: begin
                if (req_q) begin
                    if (reg_ack) cnt_dec = 1'b1;
                end else if (chunk_left == '0) begin
                    p_clr = 1'b1; state_n = S_VAL_RD;
                end else if (src_valid) begin
                    req_n = 1'b1; we_n = 1'b1; addr_n = A_FIFO;
                    wdata_n = {24'd0, src_data}; pop_n = 1'b1;
                end
            end
            S_LAST_WR: begin
                if (req_q) begin
                    if (reg_ack) begin
                        cnt_dec = 1'b1; p_clr = 1'b1; state_n = S_FIN_RD;
                    end
                end else if (src_valid) begin
                    req_n = 1'b1; we_n = 1'b1; addr_n = A_FIFO;
                    wdata_n = {24'd0, src_data}; pop_n = 1'b1;
                end
            end
            S_GO: begin
                if (req_q) begin
                    if (reg_ack) begin
                        state_n = S_IDLE; done_n = 1'b1; err_n = ERR_NONE;
                    end
                end else begin
                    req_n = 1'b1; we_n = 1'b1; addr_n = A_STS; wdata_n = GO_WORD;
                end
            end
            S_WAIT: begin
                if (p_tick) state_n = ret_q;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;  ret_q   <= S_IDLE;  err_q  <= ERR_NONE;
            req_q   <= 1'b0;    we_q    <= 1'b0;    addr_q <= '0;
            wdata_q <= '0;      src_pop <= 1'b0;    done_q <= 1'b0;
        end else begin
            state_q <= state_n; ret_q   <= ret_n;   err_q  <= err_n;
            req_q   <= req_n;   we_q    <= we_n;    addr_q <= addr_n;
            wdata_q <= wdata_n; src_pop <= pop_n;   done_q <= done_n;
        end
    end

    assign reg_req   = req_q;
    assign reg_we    = we_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign err_code  = err_q;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
                                   $stable(reg_we) && $stable(reg_wdata)));
    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cmd_len == '0) |=> (done && err_code == 2'd2 && !reg_req));
    // R9
    go_last_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_addr == A_STS) |-> (rem == '0));
    // R4
    fifo_budget_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_addr == A_FIFO) |->
        ((state_q == S_CHUNK && chunk_left != '0) || state_q == S_LAST_WR));
    // R11
    pop_chk: assert property (@(posedge clk) disable iff (rst)
        src_pop |-> (reg_req && reg_we && reg_addr == A_FIFO));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tis_cmd_sender_tb_top.sv
`timescale 1ns/1ps
module tis_cmd_sender_tb_top;
    localparam int LEN_W = 16;
    localparam int ADDR_W = 12;
    localparam int TICK = 4;
    localparam int TP = 12;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic src_valid = 1'b0;
    logic [7:0] src_data = 8'd0;
    logic src_pop;
    logic reg_req, reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [31:0] reg_wdata;
    logic reg_ack = 1'b0;
    logic [31:0] reg_rdata = 32'd0;
    logic busy, done;
    logic [1:0] err_code;

    always #2.5 clk = ~clk;

    tis_cmd_sender #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .TICK_CYCLES(TICK),
                     .TIMEOUT_POLLS(TP)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cmd_len(cmd_len),
        .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .err_code(err_code)
    );

    int checks = 0, errors = 0, cyc = 0;
    int rdy_delay, dev_burst, zero_left, valid_lag, valid_left, exp_len;
    int sts_reads, rx, wr_run, last_burst, burst_viol, max_run, pre_reads;
    int first_wr_cyc, last_alone, go_seen, total_acc, start_cyc;
    int src_idx = 0, src_len = 0;
    logic [7:0] cmd_mem [0:63];
    logic [7:0] rx_buf [0:63];

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string rq, input string what,
                          input longint act, input longint exp);
        chk(act == exp, rq, what, act, exp);
    endtask

    // cycle counter and watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                chk(1'b0, "WDOG", "watchdog expired", cyc, WD_LIMIT);
                summary_and_end();
            end
        end
    end

    // byte source
    initial begin
        forever begin
            @(negedge clk);
            if (src_pop) src_idx++;
            src_data  = cmd_mem[src_idx[5:0]];
            src_valid = (src_idx < src_len);
        end
    end

    // device register model
    initial begin
        forever begin
            @(negedge clk);
            if (reg_ack) begin
                reg_ack = 1'b0;
            end else if (reg_req) begin
                reg_ack = 1'b1;
                total_acc++;
                if (!reg_we && reg_addr == 12'h018) begin
                    bit rdy, vld, expb;
                    int b;
                    rdy = (sts_reads >= rdy_delay);
                    vld = (valid_left == 0);
                    if (valid_left > 0) valid_left--;
                    b = (zero_left > 0) ? 0 : dev_burst;
                    if (zero_left > 0) zero_left--;
                    expb = (rx < exp_len);
                    reg_rdata = {8'h00, 16'(b), vld, rdy, 2'b00, expb, 3'b000};
                    sts_reads++;
                    if (rx == 0) pre_reads++;
                    wr_run = 0;
                    last_burst = b;
                end else if (reg_we && reg_addr == 12'h024) begin
                    if (wr_run >= last_burst) burst_viol++;
                    if (rx + 1 == src_len) last_alone = (wr_run == 0) ? 1 : 0;
                    if (rx < 64) rx_buf[rx] = reg_wdata[7:0];
                    rx++;
                    if (rx == 1) first_wr_cyc = cyc;
                    wr_run++;
                    if (wr_run > max_run) max_run = wr_run;
                    valid_left = valid_lag;
                end else if (reg_we && reg_addr == 12'h018 && reg_wdata == 32'h20) begin
                    go_seen = 1;
                end
            end
        end
    end

    task automatic dev_cfg(input int rdy, input int burst, input int zeros,
                           input int vlag, input int explen, input int len);
        rdy_delay = rdy; dev_burst = burst; zero_left = zeros;
        valid_lag = vlag; valid_left = 0; exp_len = explen;
        sts_reads = 0; rx = 0; wr_run = 0; last_burst = 0; burst_viol = 0;
        max_run = 0; pre_reads = 0; first_wr_cyc = -1; last_alone = -1;
        go_seen = 0; total_acc = 0;
        for (int i = 0; i < 64; i++) cmd_mem[i] = 8'(i * 37 + len * 11 + 5);
        src_len = len; src_idx = 0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic launch(input int len);
        cmd_len = LEN_W'(len);
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string rq, output int e);
        e = -1;
        for (int k = 0; k < 20000; k++) begin
            if (done) begin
                e = int'(err_code);
                break;
            end
            @(negedge clk);
        end
        chk(e != -1, rq, "done seen", e, 0);
        @(negedge clk);
    endtask

    function automatic int mism(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (rx_buf[i] != cmd_mem[i]) m++;
        return m;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1", "busy in reset", busy, 0);
        chk_eq("R1", "done in reset", done, 0);
        chk_eq("R1", "req in reset", reg_req, 0);
        chk_eq("R1", "pop in reset", src_pop, 0);
        chk_eq("R1", "err in reset", err_code, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R1", "busy after reset", busy, 0);
        chk_eq("R1", "req after reset", reg_req, 0);
    endtask

    task automatic t_zero_len();
        dev_cfg(0, 4, 0, 0, 0, 0);
        launch(0);
        chk_eq("R2", "done next cycle", done, 1);
        chk_eq("R2", "err code", err_code, 2);
        repeat (3) @(negedge clk);
        chk_eq("R2", "bus accesses", total_acc, 0);
        chk_eq("R2", "bytes popped", src_idx, 0);
    endtask

    task automatic t_basic();
        int e;
        dev_cfg(2, 4, 0, 0, 10, 10);
        launch(10);
        wait_done("R9", e);
        chk_eq("R9", "err code", e, 0);
        chk_eq("R9", "go written", go_seen, 1);
        chk_eq("R3", "reads before first byte", pre_reads, 3);
        chk(first_wr_cyc - start_cyc >= 2 * TICK, "R3", "ready wait length",
            first_wr_cyc - start_cyc, 2 * TICK);
        chk_eq("R4", "bytes received", rx, 10);
        chk_eq("R4", "byte mismatches", mism(10), 0);
        chk_eq("R4", "burst overruns", burst_viol, 0);
        chk_eq("R5", "largest chunk", max_run, 4);
        chk_eq("R8", "last byte alone", last_alone, 1);
        chk_eq("R11", "bytes popped", src_idx, 10);
    endtask

    task automatic t_len_one();
        int e;
        dev_cfg(0, 4, 0, 0, 1, 1);
        launch(1);
        wait_done("R8", e);
        chk_eq("R8", "err code", e, 0);
        chk_eq("R8", "bytes received", rx, 1);
        chk_eq("R8", "last byte alone", last_alone, 1);
        chk_eq("R9", "go written", go_seen, 1);
    endtask

    task automatic t_wide_burst();
        int e;
        dev_cfg(0, 64, 0, 0, 6, 6);
        launch(6);
        wait_done("R5", e);
        chk_eq("R5", "err code", e, 0);
        chk_eq("R5", "chunk capped at len-1", max_run, 5);
        chk_eq("R5", "byte mismatches", mism(6), 0);
        chk_eq("R8", "last byte alone", last_alone, 1);
    endtask

    task automatic t_slow_valid();
        int e;
        dev_cfg(0, 1, 0, 2, 5, 5);
        launch(5);
        wait_done("R5", e);
        chk_eq("R5", "err code", e, 0);
        chk_eq("R5", "bytes received", rx, 5);
        chk_eq("R4", "burst overruns", burst_viol, 0);
        chk_eq("R5", "byte mismatches", mism(5), 0);
    endtask

    task automatic t_ready_timeout();
        int e;
        dev_cfg(1000, 4, 0, 0, 8, 8);
        launch(8);
        wait_done("R3", e);
        chk_eq("R3", "err code", e, 1);
        chk_eq("R3", "status reads", sts_reads, TP);
        chk_eq("R3", "bytes written", rx, 0);
        chk_eq("R3", "go written", go_seen, 0);
    endtask

    task automatic t_burst_stall();
        int e;
        dev_cfg(0, 2, 3, 0, 4, 4);
        launch(4);
        wait_done("R7", e);
        chk_eq("R7", "err code", e, 0);
        chk_eq("R7", "bytes received", rx, 4);
        chk_eq("R7", "byte mismatches", mism(4), 0);
        chk_eq("R7", "burst overruns", burst_viol, 0);
    endtask

    task automatic t_burst_timeout();
        int e;
        dev_cfg(0, 0, 0, 0, 8, 8);
        launch(8);
        wait_done("R7", e);
        chk_eq("R7", "err code", e, 1);
        chk_eq("R7", "status reads", sts_reads, 1 + TP);
        chk_eq("R7", "bytes written", rx, 0);
    endtask

    task automatic t_overflow();
        int e;
        dev_cfg(0, 4, 0, 0, 3, 8);
        launch(8);
        wait_done("R6", e);
        chk_eq("R6", "err code", e, 2);
        chk_eq("R6", "bytes written", rx, 4);
        chk_eq("R6", "go written", go_seen, 0);
    endtask

    task automatic t_final_expect();
        int e;
        dev_cfg(0, 8, 0, 0, 6, 5);
        launch(5);
        wait_done("R8", e);
        chk_eq("R8", "err code", e, 2);
        chk_eq("R8", "bytes written", rx, 5);
        chk_eq("R8", "go written", go_seen, 0);
    endtask

    task automatic t_start_busy();
        int e;
        dev_cfg(0, 2, 0, 1, 6, 6);
        launch(6);
        repeat (5) @(negedge clk);
        cmd_len = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R10", "no early done", done, 0);
        wait_done("R10", e);
        chk_eq("R10", "err code", e, 0);
        chk_eq("R10", "bytes received", rx, 6);
        chk_eq("R10", "byte mismatches", mism(6), 0);
        chk_eq("R11", "bytes popped", src_idx, 6);
    endtask

    initial begin
        t_reset();
        t_zero_len();
        t_basic();
        t_len_one();
        t_wide_burst();
        t_slow_valid();
        t_ready_timeout();
        t_burst_stall();
        t_burst_timeout();
        t_overflow();
        t_final_expect();
        t_start_busy();
        summary_and_end();
    end

endmodule